// File: doc/BRIEF.md
# Flash Access Controller with Prescaled Timing

This block sits between a debug port and an on-chip flash array. It runs byte reads, byte writes and page erases on the array. Software reaches it through a simple parallel register port with two registers: a 10-bit data/status register and an 8-bit scale register. A separate command input starts an operation by giving an opcode and a 16-bit address. The scan chain that would normally carry these accesses is not part of the block.

Program and erase durations are counted in ticks of a power-of-two prescaler. The prescaler divides the system clock by 2^N, where N is the low nibble of the scale register. The all-ones value of that nibble is reserved and blocks every array access. A lock input from the array reports whether the addressed location is protected. The block drives the array's read strobe and its output and sense enables. Two scale bits select how these behave: a short gated strobe instead of a full-cycle one, and enables that stay on permanently.

Top module: `flash_access_ctrl`

## Requirements
- R1: After reset both registers read as zero, and the array strobes and enables are all low.
- R2: The scale register holds bit 7 (short strobe), bit 6 (enables always on) and bits 3:0 (prescaler exponent N). Its bits 5:4 always read 0, and writing them has no effect.
- R3: A command with a nonzero opcode (1 read, 2 write, 3 erase) issued while idle makes BUSY (data register bit 0) read 1 on the next clock. The same command clears FAIL (bit 1).
- R4: While BUSY is 1, commands and register writes are ignored. No second operation starts, and neither register changes.
- R5: A read keeps BUSY high for exactly 2 clocks. After that, data register bits 9:2 hold the array byte at the command address.
- R6: A write keeps BUSY high for 4·2^N + 2 clocks. It issues exactly one write pulse, which carries the command address and data bits 9:2, and it leaves FAIL at 0.
- R7: An erase keeps BUSY high for 64·2^N + 2 clocks. It issues exactly one erase pulse for the command address.
- R8: With N = 15, any operation is refused. BUSY stays high for 1 clock, FAIL becomes 1, and no strobe, write or erase pulse reaches the array.
- R9: A write or erase to an address that the array reports as locked is refused in the same way as R8. Reads of locked addresses complete normally.
- R10: With bit 7 = 0, the read strobe is high for the whole second clock of a read. With bit 7 = 1, it is high only where the fast one-shot gate input is also high.
- R11: With bit 6 = 1, the output and sense enables stay high at all times. With bit 6 = 0, they are high only during the second clock of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register select: 0 data/status, 1 scale |
| regWe | input | 1 | Register write enable |
| regWrData | input | 10 | Register write value (data byte in bits 9:2; scale in bits 7:0) |
| regRdData | output | 10 | Selected register value |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Opcode: 0 none, 1 read, 2 write, 3 erase |
| cmdAddr | input | 16 | Command byte address |
| oneShotGate | input | 1 | Fast enable that shapes the short read strobe |
| arrAddr | output | 16 | Array address (latched command address) |
| arrWrData | output | 8 | Byte to program |
| arrWe | output | 1 | One-clock program pulse |
| arrErase | output | 1 | One-clock page erase pulse |
| arrRdStb | output | 1 | Array read strobe |
| arrOutEn | output | 1 | Array output enable |
| arrSenseEn | output | 1 | Array sense amplifier enable |
| arrRdData | input | 8 | Byte from the array |
| arrLocked | input | 1 | Array reports the address in arrAddr as locked |

## Verification
The bench measures each operation's busy window against the 2^N formula at several exponents. An off-by-one in the prescaler mask or the tick counter would show up there as a window that is one tick long or short. It fires a command and register writes in the middle of a write. A design that accepted them would leave a changed data byte, a changed exponent or an extra array pulse. Reserved-code and locked-page requests are checked for a one-clock busy window, FAIL set and no array activity; a leak would corrupt the bench's shadow copy of the array. Strobe and enable counts per read catch a strobe that ignores the one-shot gate, and enables that drop while forced on.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam int EXP_W = 4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } flashOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WAIT,
    ST_COMMIT
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic clrFail;
    logic setFail;
    logic readActive;
    logic captureRead;
    logic commitWrite;
    logic commitErase;
  } ctrlStrobes_t;

endpackage

// File: rtl/flashctl_ctrl.sv
module flashctl_ctrl
  import flashctl_pkg::*;
#(
  parameter int WRITE_TICKS = 4,
  parameter int ERASE_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [EXP_W-1:0] prescaleExp,
  input  logic             lockIn,
  output logic             busy,
  output ctrlStrobes_t     strobes
);

  localparam int CNT_W  = (1 << EXP_W) - 1;
  localparam int TICK_W = $clog2(ERASE_TICKS + 1);
  localparam logic [EXP_W-1:0] EXP_OFF = '1;
  localparam logic [TICK_W-1:0] WR_LAST = TICK_W'(WRITE_TICKS - 1);
  localparam logic [TICK_W-1:0] ER_LAST = TICK_W'(ERASE_TICKS - 1);

  ctrlState_e state, nextState;
  flashOp_e   opQ;
  logic [CNT_W-1:0]  preCnt;
  logic [CNT_W-1:0]  preMask;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] lastTick;
  logic tick;
  logic refuse;

  assign preMask  = ~({CNT_W{1'b1}} << prescaleExp);
  assign tick     = (state == ST_WAIT) && ((preCnt & preMask) == preMask);
  assign lastTick = (opQ == OP_ERASE) ? ER_LAST : WR_LAST;
  assign refuse   = (prescaleExp == EXP_OFF) || ((opQ != OP_READ) && lockIn);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && (flashOp_e'(cmdOp) != OP_NONE)) begin
          strobes.latchCmd = 1'b1;
          strobes.clrFail  = 1'b1;
          nextState        = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (refuse) begin
          strobes.setFail = 1'b1;
          nextState       = ST_IDLE;
        end else if (opQ == OP_READ) begin
          nextState = ST_READ;
        end else begin
          nextState = ST_WAIT;
        end
      end
      ST_READ: begin
        strobes.readActive  = 1'b1;
        strobes.captureRead = 1'b1;
        nextState           = ST_IDLE;
      end
      ST_WAIT: begin
        if (tick && (tickCnt == lastTick)) nextState = ST_COMMIT;
      end
      ST_COMMIT: begin
        strobes.commitWrite = (opQ == OP_WRITE);
        strobes.commitErase = (opQ == OP_ERASE);
        nextState           = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_NONE;
    end else begin
      state <= nextState;
      if (strobes.latchCmd) opQ <= flashOp_e'(cmdOp);
    end
  end

  // prescaler and tick counter restart every time the wait phase is entered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (state != ST_WAIT) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (tick) tickCnt <= tickCnt + 1'b1;
    end
  end

  assert_busy_on_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && (cmdOp != 2'd0)) |=> busy);

  assert_reserved_refuses_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && (prescaleExp == EXP_OFF)) |=> !busy);

  assert_commit_ends_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitWrite || strobes.commitErase) |=> !busy);

  assert_read_two_cycles_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureRead |-> $past(busy));

  assert_single_array_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.commitWrite, strobes.commitErase, strobes.readActive, strobes.setFail}));

endmodule

// File: rtl/flashctl_datapath.sv
module flashctl_datapath
  import flashctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  ctrlStrobes_t      strobes,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [DATA_W+1:0] regWrData,
  output logic [DATA_W+1:0] regRdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              oneShotGate,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic              arrWe,
  output logic              arrErase,
  output logic              arrRdStb,
  output logic              arrOutEn,
  output logic              arrSenseEn,
  output logic [EXP_W-1:0]  prescaleExp
);

  localparam int REG_W = DATA_W + 2;

  logic [DATA_W-1:0] dataQ;
  logic              failQ;
  logic              shortStbQ;
  logic              enAlwaysQ;
  logic [EXP_W-1:0]  expQ;
  logic [ADDR_W-1:0] addrQ;
  logic              wrData, wrScale;
  logic              unusedWrBits;

  assign wrData  = regWe && !busy && !regSel;
  assign wrScale = regWe && !busy && regSel;
  assign unusedWrBits = ^{regWrData[1:0], regWrData[REG_W-1:8], regWrData[5:4]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      failQ <= 1'b0;
      addrQ <= '0;
    end else begin
      if (strobes.captureRead) dataQ <= arrRdData;
      else if (wrData)         dataQ <= regWrData[REG_W-1:2];
      if (strobes.setFail)      failQ <= 1'b1;
      else if (strobes.clrFail) failQ <= 1'b0;
      if (strobes.latchCmd) addrQ <= cmdAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortStbQ <= 1'b0;
      enAlwaysQ <= 1'b0;
      expQ      <= '0;
    end else if (wrScale) begin
      shortStbQ <= regWrData[7];
      enAlwaysQ <= regWrData[6];
      expQ      <= regWrData[EXP_W-1:0];
    end
  end

  always_comb begin
    if (regSel) regRdData = {{(REG_W-8){1'b0}}, shortStbQ, enAlwaysQ, 2'b00, expQ};
    else        regRdData = {dataQ, failQ, busy};
  end

  assign prescaleExp = expQ;
  assign arrAddr     = addrQ;
  assign arrWrData   = dataQ;
  assign arrWe       = strobes.commitWrite;
  assign arrErase    = strobes.commitErase;
  assign arrRdStb    = strobes.readActive && (!shortStbQ || oneShotGate);
  assign arrOutEn    = enAlwaysQ || strobes.readActive;
  assign arrSenseEn  = enAlwaysQ || strobes.readActive;

  assert_reserved_bits_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (regRdData[5:4] == 2'b00));

  assert_scale_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe) |=> ($stable(expQ) && $stable(shortStbQ) && $stable(enAlwaysQ)));

  assert_enables_forced_R11: assert property (@(posedge clk) disable iff (!rstN)
    enAlwaysQ |-> (arrOutEn && arrSenseEn));

  assert_strobe_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    arrRdStb |-> (arrOutEn && busy));

endmodule

// File: rtl/flash_access_ctrl.sv
module flash_access_ctrl
  import flashctl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 4,
  parameter int ERASE_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [DATA_W+1:0] regWrData,
  output logic [DATA_W+1:0] regRdData,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              oneShotGate,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic              arrWe,
  output logic              arrErase,
  output logic              arrRdStb,
  output logic              arrOutEn,
  output logic              arrSenseEn,
  input  logic [DATA_W-1:0] arrRdData,
  input  logic              arrLocked
);

  ctrlStrobes_t     strobes;
  logic             busy;
  logic [EXP_W-1:0] prescaleExp;

  flashctl_ctrl #(
    .WRITE_TICKS(WRITE_TICKS),
    .ERASE_TICKS(ERASE_TICKS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .prescaleExp(prescaleExp),
    .lockIn     (arrLocked),
    .busy       (busy),
    .strobes    (strobes)
  );

  flashctl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .strobes    (strobes),
    .regSel     (regSel),
    .regWe      (regWe),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .cmdAddr    (cmdAddr),
    .oneShotGate(oneShotGate),
    .arrRdData  (arrRdData),
    .arrAddr    (arrAddr),
    .arrWrData  (arrWrData),
    .arrWe      (arrWe),
    .arrErase   (arrErase),
    .arrRdStb   (arrRdStb),
    .arrOutEn   (arrOutEn),
    .arrSenseEn (arrSenseEn),
    .prescaleExp(prescaleExp)
  );

endmodule

// File: tb/flash_array_model.sv
module flash_array_model #(
  parameter int PAGE_BYTES = 512,
  parameter int PAGES      = 4,
  parameter int LOCK_PAGE  = 3
) (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        we,
  input  logic        erase,
  input  logic        outEn,
  input  logic        senseEn,
  output logic [7:0]  rdData,
  output logic        locked
);

  localparam int BYTES = PAGE_BYTES * PAGES;
  localparam int IDX_W = $clog2(BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [7:0] mem [BYTES];
  logic [IDX_W-1:0] idx;
  int pageNum;

  assign idx     = addr[IDX_W-1:0];
  assign pageNum = int'(idx) / PAGE_BYTES;
  assign locked  = (pageNum == LOCK_PAGE);
  assign rdData  = (outEn && senseEn) ? mem[idx] : 8'h00;

  initial begin
    for (int i = 0; i < BYTES; i++) mem[i] = 8'hFF;
  end

  always @(posedge clk) begin
    if (we) mem[idx] <= mem[idx] & wrData;
    if (erase) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[pageNum * PAGE_BYTES + i] <= 8'hFF;
    end
  end

endmodule

// File: tb/test_flash_access_ctrl.sv
module test_flash_access_ctrl;

  localparam logic [1:0] RD = 2'd1, WR = 2'd2, ER = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWe = 1'b0;
  logic [9:0] regWrData = '0;
  logic [9:0] regRdData;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [15:0] cmdAddr = '0;
  logic oneShotGate = 1'b0;
  logic [15:0] arrAddr;
  logic [7:0] arrWrData, arrRdData;
  logic arrWe, arrErase, arrRdStb, arrOutEn, arrSenseEn, arrLocked;

  int checks = 0, fails = 0;
  int weTotal = 0, erTotal = 0, stbTotal = 0, oeTotal = 0;
  int curExp = 0;
  logic [7:0] shadow [2048];
  logic [7:0] lastData = 8'h00;

  always #10 clk = ~clk;

  flash_access_ctrl i_flash_access_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe), .regWrData(regWrData),
    .regRdData(regRdData), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .oneShotGate(oneShotGate), .arrAddr(arrAddr), .arrWrData(arrWrData), .arrWe(arrWe),
    .arrErase(arrErase), .arrRdStb(arrRdStb), .arrOutEn(arrOutEn), .arrSenseEn(arrSenseEn),
    .arrRdData(arrRdData), .arrLocked(arrLocked)
  );

  flash_array_model i_array (
    .clk(clk), .addr(arrAddr), .wrData(arrWrData), .we(arrWe), .erase(arrErase),
    .outEn(arrOutEn), .senseEn(arrSenseEn), .rdData(arrRdData), .locked(arrLocked)
  );

  // activity monitors: sampled at the edge that ends each cycle
  always @(posedge clk) begin
    if (arrWe) weTotal++;
    if (arrErase) erTotal++;
    if (arrRdStb) stbTotal++;
    if (arrOutEn) oeTotal++;
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finishRun();
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int expCycles(input logic [1:0] op, input int n, input bit refused);
    if (refused) return 1;
    if (op == RD) return 2;
    if (op == WR) return 4 * (1 << n) + 2;
    return 64 * (1 << n) + 2;
  endfunction

  function automatic bit expRefused(input logic [1:0] op, input int n, input logic [15:0] a);
    return (n == 15) || ((op != RD) && (a[10:9] == 2'd3));
  endfunction

  task automatic setScale(input bit shortStb, input bit enAlways, input int n);
    @(negedge clk);
    regSel = 1'b1; regWe = 1'b1;
    regWrData = {2'b11, shortStb, enAlways, 2'b11, 4'(n)};
    @(negedge clk);
    regWe = 1'b0; regSel = 1'b0;
    curExp = n;
  endtask

  // runs one operation and checks duration, FAIL, data and array activity
  task automatic runOp(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                       input bit inject);
    int cyc, we0, er0, n;
    bit refused;
    n = curExp;
    refused = expRefused(op, n, a);
    @(negedge clk);
    if (op == WR) begin
      regSel = 1'b0; regWe = 1'b1; regWrData = {wd, 2'b00};
      @(negedge clk);
      regWe = 1'b0;
      lastData = wd;
    end
    we0 = weTotal; er0 = erTotal;
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0;
    check(regRdData[0] == 1'b1, "R3 busy after accept", regRdData[0], 1);
    check(regRdData[1] == 1'b0, "R3 fail cleared", regRdData[1], 0);
    cyc = 0;
    while (regRdData[0] && cyc < 70000) begin
      cyc++;
      if (inject && cyc == 2) begin
        cmdValid = 1'b1; cmdOp = RD; cmdAddr = 16'h0005;
        regWe = 1'b1; regSel = 1'b0; regWrData = {8'hAA, 2'b00};
      end else if (inject && cyc == 3) begin
        cmdValid = 1'b0; regSel = 1'b1; regWrData = 10'h0C3;
      end else if (inject && cyc == 4) begin
        regWe = 1'b0; regSel = 1'b0;
      end
      @(negedge clk);
    end
    if (op == RD)      check(cyc == expCycles(op, n, refused), "R5 read busy cycles", cyc, expCycles(op, n, refused));
    else if (op == WR) check(cyc == expCycles(op, n, refused), "R6 write busy cycles", cyc, expCycles(op, n, refused));
    else               check(cyc == expCycles(op, n, refused), "R7 erase busy cycles", cyc, expCycles(op, n, refused));
    check(regRdData[1] == refused, "R8/R9 fail flag", regRdData[1], refused);
    check((weTotal - we0) == ((op == WR && !refused) ? 1 : 0), "R6 write pulses",
          weTotal - we0, (op == WR && !refused) ? 1 : 0);
    check((erTotal - er0) == ((op == ER && !refused) ? 1 : 0), "R7 erase pulses",
          erTotal - er0, (op == ER && !refused) ? 1 : 0);
    if (!refused) begin
      if (op == WR) shadow[a[10:0]] = shadow[a[10:0]] & wd;
      if (op == ER) for (int i = 0; i < 512; i++) shadow[{a[10:9], 9'(i)}] = 8'hFF;
      if (op == RD) lastData = shadow[a[10:0]];
    end
    check(regRdData[9:2] == lastData, "R5 data byte", regRdData[9:2], lastData);
  endtask

  initial begin
    int seedDummy, stb0, oe0, n;
    logic [1:0] op;
    logic [15:0] a;
    seedDummy = $urandom(20240917);
    for (int i = 0; i < 2048; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regSel = 1'b0;
    #1 check(regRdData == 10'h000, "R1 data/status reset", regRdData, 0);
    regSel = 1'b1;
    #1 check(regRdData == 10'h000, "R1 scale reset", regRdData, 0);
    check({arrRdStb, arrOutEn, arrSenseEn, arrWe, arrErase} == 5'b0, "R1 array idle",
          {arrRdStb, arrOutEn, arrSenseEn, arrWe, arrErase}, 0);
    regSel = 1'b0;

    // R2 reserved bits
    setScale(1'b1, 1'b0, 5);
    regSel = 1'b1;
    #1 check(regRdData == 10'h085, "R2 scale readback", regRdData, 10'h085);
    regSel = 1'b0;
    setScale(1'b0, 1'b0, 0);

    // directed write/read/erase at N=0
    runOp(RD, 16'h0005, 8'h00, 1'b0);
    runOp(WR, 16'h0005, 8'h3C, 1'b0);
    runOp(RD, 16'h0005, 8'h00, 1'b0);
    runOp(WR, 16'h0005, 8'hF0, 1'b0);
    runOp(RD, 16'h0005, 8'h00, 1'b0);
    check(regRdData[9:2] == 8'h30, "R6 bits only cleared", regRdData[9:2], 8'h30);
    runOp(ER, 16'h0005, 8'h00, 1'b0);
    runOp(RD, 16'h0005, 8'h00, 1'b0);

    // R8 reserved code refuses everything
    setScale(1'b0, 1'b0, 15);
    stb0 = stbTotal;
    runOp(RD, 16'h0010, 8'h00, 1'b0);
    runOp(WR, 16'h0010, 8'h00, 1'b0);
    runOp(ER, 16'h0010, 8'h00, 1'b0);
    check(stbTotal == stb0, "R8 no read strobe", stbTotal - stb0, 0);

    // R9 locked page
    setScale(1'b0, 1'b0, 1);
    runOp(WR, 16'h0610, 8'h00, 1'b0);
    runOp(ER, 16'h0610, 8'h00, 1'b0);
    runOp(RD, 16'h0610, 8'h00, 1'b0);
    check(regRdData[1] == 1'b0, "R9 locked read completes", regRdData[1], 0);

    // R4 requests while busy are dropped
    runOp(WR, 16'h0210, 8'h0F, 1'b1);
    check(regRdData[9:2] == 8'h0F, "R4 data not overwritten", regRdData[9:2], 8'h0F);
    regSel = 1'b1;
    #1 check(regRdData[3:0] == 4'd1, "R4 scale unchanged", regRdData[3:0], 1);
    regSel = 1'b0;
    repeat (3) @(negedge clk);
    check(regRdData[0] == 1'b0, "R4 no second op", regRdData[0], 0);

    // R10 strobe width, R11 enables
    setScale(1'b0, 1'b0, 0);
    stb0 = stbTotal; oe0 = oeTotal;
    runOp(RD, 16'h0210, 8'h00, 1'b0);
    check(stbTotal - stb0 == 1, "R10 full strobe", stbTotal - stb0, 1);
    check(oeTotal - oe0 == 1, "R11 enables during read only", oeTotal - oe0, 1);
    setScale(1'b1, 1'b0, 0);
    oneShotGate = 1'b0;
    stb0 = stbTotal;
    runOp(RD, 16'h0210, 8'h00, 1'b0);
    check(stbTotal - stb0 == 0, "R10 gated strobe off", stbTotal - stb0, 0);
    oneShotGate = 1'b1;
    stb0 = stbTotal;
    runOp(RD, 16'h0210, 8'h00, 1'b0);
    check(stbTotal - stb0 == 1, "R10 gated strobe on", stbTotal - stb0, 1);
    oneShotGate = 1'b0;
    setScale(1'b0, 1'b1, 0);
    #1 check(arrOutEn && arrSenseEn, "R11 enables forced on", {arrOutEn, arrSenseEn}, 3);
    setScale(1'b0, 1'b0, 0);
    #1 check(!arrOutEn && !arrSenseEn, "R11 enables off idle", {arrOutEn, arrSenseEn}, 0);

    // erase at a larger exponent
    setScale(1'b0, 1'b0, 2);
    runOp(ER, 16'h0210, 8'h00, 1'b0);
    runOp(RD, 16'h0210, 8'h00, 1'b0);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      n = $urandom % 8;
      n = (n == 7) ? 15 : (n % 3);
      setScale(1'b0, 1'b0, n);
      op = 2'(1 + ($urandom % 3));
      if (op == ER && ($urandom % 2) == 1) op = WR;
      a = 16'($urandom) & 16'h07FF;
      runOp(op, a, 8'($urandom), 1'b0);
    end

    finishRun();
  end

endmodule